// File: doc/BRIEF.md
# Float Bit-Manipulation Operation Unit

This unit runs the inexpensive single-precision operations of a floating-point datapath. Each one works directly on the IEEE-754 bit pattern, so no adder, multiplier or normaliser is needed. It covers magnitude (absolute value), pass-through copy, greater-than and equality tests, a select driven by a flags word, sign transfer, and the magic-constant reciprocal square-root seed. The two comparisons return the floating value 1.0 or 0.0, not a single bit, so later float operations can use the result as it is.

The unit is a fixed two-stage pipeline. A valid strobe comes in with the opcode, two operands and the flags word. A valid strobe and a result come out exactly two clock cycles later. A new operation can be issued on every cycle. Opcodes outside the set handled here still travel through the pipeline and come out as a zero result. The reset input is asynchronous and active low. Its release is synchronised inside the unit.

Top module: `fbit_unit`

## Requirements
- R1: `out_valid` is high exactly two clock cycles after a cycle in which `in_valid` was high, and low otherwise. An operation can be accepted on every cycle.
- R2: While reset is held and after it is released, before any operation completes, `out_valid` is 0 and `out_result` is 0.
- R3: Opcode 4 (magnitude) returns A with bit 31 cleared.
- R4: Opcode 12 (copy) returns A unchanged, bit for bit.
- R5: Opcode 10 (greater-than) returns 0x3F800000 when A > B as real numbers and 0x00000000 otherwise. +0 and −0 compare equal. Any NaN operand (exponent bits 30:23 all ones, fraction nonzero) gives 0.
- R6: Opcode 11 (equality) returns 0x3F800000 when A == B as real numbers and 0x00000000 otherwise. +0 equals −0. Any NaN operand gives 0.
- R7: Opcode 13 (select) returns A when the flags word is nonzero and B when it is zero.
- R8: Opcode 14 (sign transfer) returns A with bit 31 inverted when B is less than zero, and A otherwise. A B of −0 or NaN is not less than zero.
- R9: Opcode 15 (seed) returns 0x5F3759DF minus (A shifted right by one), modulo 2^32.
- R10: Any other opcode (0–3, 5–9) completes with `out_valid` high and `out_result` 0.
- R11: `out_result` keeps its value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| in_valid | input | 1 | Operation issue strobe |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | Operand A (single-precision bit pattern) |
| in_b | input | 32 | Operand B (single-precision bit pattern) |
| in_flags | input | 32 | Flags word consulted by select |
| out_valid | output | 1 | Result strobe, two cycles after issue |
| out_result | output | 32 | Operation result |

## Verification
Two operations are in flight in the same cycle whenever issues come back to back. While one operation is being captured, the one issued before it is being evaluated and registered. The bench issues long unbroken runs with the opcode changing every cycle, mixed with idle gaps. Each result is compared in its own cycle against a bench model of the operation issued two cycles earlier. A result landing one cycle early or late, or taking a neighbour's opcode or operands, therefore shows up as a mismatch. The idle cycles between runs also show whether the result register holds its value while nothing completes.

// File: rtl/fbit_pkg.sv
package fbit_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned EXP_HI = WORD_W - 2;
  localparam int unsigned EXP_LO = 23;

  localparam logic [WORD_W-1:0] FP_ONE  = 32'h3F80_0000;
  localparam logic [WORD_W-1:0] FP_ZERO = '0;

  typedef enum logic [OP_W-1:0] {
    OP_MAG    = 4'd4,
    OP_ABOVE  = 4'd10,
    OP_SAME   = 4'd11,
    OP_PASS   = 4'd12,
    OP_PICK   = 4'd13,
    OP_SGNXFR = 4'd14,
    OP_RSQSD  = 4'd15
  } fbit_op_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [WORD_W-1:0] a;
    logic [WORD_W-1:0] b;
    logic              flag_set;
  } fbit_issue_t;

endpackage

// File: rtl/fbit_rst_sync.sv
module fbit_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = 1'b1;
      end else begin : g_rest
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/fbit_compare.sv
module fbit_compare
  import fbit_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic              a_above_b,
  output logic              a_same_b
);

  logic a_nan, b_nan, any_nan;
  logic a_zero, b_zero, both_zero;
  logic mag_gt, mag_lt;

  always_comb begin
    a_nan     = (&a[EXP_HI:EXP_LO]) & (|a[EXP_LO-1:0]);
    b_nan     = (&b[EXP_HI:EXP_LO]) & (|b[EXP_LO-1:0]);
    any_nan   = a_nan | b_nan;
    a_zero    = ~|a[WORD_W-2:0];
    b_zero    = ~|b[WORD_W-2:0];
    both_zero = a_zero & b_zero;
    mag_gt    = a[WORD_W-2:0] > b[WORD_W-2:0];
    mag_lt    = a[WORD_W-2:0] < b[WORD_W-2:0];
  end

  always_comb begin
    if (any_nan || both_zero) begin
      a_above_b = 1'b0;
    end else if (a[WORD_W-1] != b[WORD_W-1]) begin
      a_above_b = ~a[WORD_W-1];
    end else if (!a[WORD_W-1]) begin
      a_above_b = mag_gt;
    end else begin
      a_above_b = mag_lt;
    end
  end

  always_comb begin
    a_same_b = ~any_nan & ((a == b) | both_zero);
  end

endmodule

// File: rtl/fbit_sign_ops.sv
module fbit_sign_ops
  import fbit_pkg::*;
#(
  parameter logic [WORD_W-1:0] SEED_MAGIC = 32'h5F37_59DF
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] mag_a,
  output logic [WORD_W-1:0] sgnxfr_a,
  output logic [WORD_W-1:0] seed_a
);

  logic b_zero, b_nan, b_negative;

  always_comb begin
    b_zero     = ~|b[WORD_W-2:0];
    b_nan      = (&b[EXP_HI:EXP_LO]) & (|b[EXP_LO-1:0]);
    b_negative = b[WORD_W-1] & ~b_zero & ~b_nan;
  end

  always_comb begin
    mag_a    = {1'b0, a[WORD_W-2:0]};
    sgnxfr_a = {a[WORD_W-1] ^ b_negative, a[WORD_W-2:0]};
    seed_a   = SEED_MAGIC - {1'b0, a[WORD_W-1:1]};
  end

endmodule

// File: rtl/fbit_unit.sv
module fbit_unit
  import fbit_pkg::*;
#(
  parameter int unsigned      FLAG_W      = 32,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] SEED_MAGIC = 32'h5F37_59DF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result
);

  logic rst_sync_n;

  fbit_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Stage 1: issue capture
  fbit_issue_t issue_d, issue_q;
  logic        s1_valid_d, s1_valid_q;
  logic        issue_en;

  always_comb begin
    issue_en          = in_valid;
    s1_valid_d        = in_valid;
    issue_d.op        = in_op;
    issue_d.a         = in_a;
    issue_d.b         = in_b;
    issue_d.flag_set  = |in_flags;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      issue_q <= '0;
    end else if (issue_en) begin
      issue_q <= issue_d;
    end
  end

  // Stage 2: evaluate and register the result
  logic              above, same;
  logic [WORD_W-1:0] mag_v, sgnxfr_v, seed_v;

  fbit_compare u_cmp (
    .a         (issue_q.a),
    .b         (issue_q.b),
    .a_above_b (above),
    .a_same_b  (same)
  );

  fbit_sign_ops #(.SEED_MAGIC(SEED_MAGIC)) u_sgn (
    .a        (issue_q.a),
    .b        (issue_q.b),
    .mag_a    (mag_v),
    .sgnxfr_a (sgnxfr_v),
    .seed_a   (seed_v)
  );

  logic [WORD_W-1:0] res_d, res_q;
  logic              res_en;
  logic              ov_d, ov_q;

  always_comb begin
    unique case (issue_q.op)
      OP_MAG:    res_d = mag_v;
      OP_ABOVE:  res_d = above ? FP_ONE : FP_ZERO;
      OP_SAME:   res_d = same  ? FP_ONE : FP_ZERO;
      OP_PASS:   res_d = issue_q.a;
      OP_PICK:   res_d = issue_q.flag_set ? issue_q.a : issue_q.b;
      OP_SGNXFR: res_d = sgnxfr_v;
      OP_RSQSD:  res_d = seed_v;
      default:   res_d = FP_ZERO;
    endcase
    res_en = s1_valid_q;
    ov_d   = s1_valid_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ov_q <= 1'b0;
    end else begin
      ov_q <= ov_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign out_valid  = ov_q;
  assign out_result = res_q;

endmodule

// File: rtl/fbit_unit_chk.sv
module fbit_unit_chk
  import fbit_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OP_W-1:0]   in_op,
  input logic [WORD_W-1:0] in_a,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_result
);

  a_r1_issue_completes: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  a_r1_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  a_r3_mag_sign_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_MAG) |=> ##1 !out_result[WORD_W-1]);

  a_r4_copy_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_PASS) |=> ##1 (out_result == $past(in_a, 2)));

  a_r5_r6_compare_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == OP_ABOVE || in_op == OP_SAME))
      |=> ##1 (out_result == FP_ONE || out_result == FP_ZERO));

  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_result));

endmodule

bind fbit_unit fbit_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_a       (in_a),
  .out_valid  (out_valid),
  .out_result (out_result)
);

// File: tb/sim_fbit_unit.sv
module sim_fbit_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  in_op;
  logic [31:0] in_a, in_b, in_flags;
  logic        out_valid;
  logic [31:0] out_result;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  fbit_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_flags(in_flags),
    .out_valid(out_valid), .out_result(out_result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // expected pipeline, filled at issue time
  logic        ev1 = 0, ev2 = 0;
  logic [31:0] er1 = 0, er2 = 0;
  logic [3:0]  eo1 = 0, eo2 = 0;
  logic [31:0] last_res = 0;

  function automatic bit is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic longint order_key(input logic [31:0] x);
    longint m;
    m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] f);
    bit nan;
    nan = is_nan(a) || is_nan(b);
    case (op)
      4'd4:  return a & 32'h7FFF_FFFF;
      4'd10: return (!nan && order_key(a) > order_key(b)) ? 32'h3F80_0000 : 32'h0;
      4'd11: return (!nan && order_key(a) == order_key(b)) ? 32'h3F80_0000 : 32'h0;
      4'd12: return a;
      4'd13: return (f != 0) ? a : b;
      4'd14: return (!is_nan(b) && order_key(b) < 0) ? (a ^ 32'h8000_0000) : a;
      4'd15: return 32'h5F37_59DF - (a >> 1);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd4:  return "R3";
      4'd10: return "R5";
      4'd11: return "R6";
      4'd12: return "R4";
      4'd13: return "R7";
      4'd14: return "R8";
      4'd15: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_out();
    n_cmp++;
    if (out_valid !== ev2) begin
      n_bad++;
      $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, ev2);
    end
    if (ev2) begin
      n_cmp++;
      if (out_result !== er2) begin
        n_bad++;
        $display("FAIL %s op=%0d result actual=%08h expected=%08h", req_of(eo2), eo2, out_result, er2);
      end
      last_res = er2;
    end else begin
      n_cmp++;
      if (out_result !== last_res) begin
        n_bad++;
        $display("FAIL R11 held result actual=%08h expected=%08h", out_result, last_res);
      end
    end
  endtask

  // one cycle: check outputs, shift the model, drive the next issue
  task automatic cyc(input bit v, input logic [3:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic [31:0] f);
    @(negedge clk);
    check_out();
    ev2 = ev1; er2 = er1; eo2 = eo1;
    ev1 = v;   er1 = model(op, a, b, f); eo1 = op;
    in_valid = v; in_op = op; in_a = a; in_b = b; in_flags = f;
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom % 10)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h7FC0_0001;
      3: return 32'h7F80_0000;
      4: return 32'hFF80_0000;
      5: return 32'h3F80_0000;
      6: return 32'hBF80_0000;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [3:0] pick_op();
    logic [3:0] ops [8] = '{4'd4, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15, 4'd0};
    if ($urandom % 8 == 0) return 4'($urandom % 10);
    return ops[$urandom % 8];
  endfunction

  initial begin
    void'($urandom(32'h00C0_FFEE));
    rst_n = 1'b0; in_valid = 0; in_op = 0; in_a = 0; in_b = 0; in_flags = 0;
    // R2: reset state while held
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0);
    rst_n = 1'b1;
    // R2: state after release, before any issue
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0);

    // directed corners
    cyc(1, 4'd4,  32'hC049_0FDB, 0, 0);              // R3 negative magnitude
    cyc(1, 4'd12, 32'h7FC0_1234, 0, 0);              // R4 NaN copied exactly
    cyc(1, 4'd10, 32'h0000_0000, 32'h8000_0000, 0);  // R5 +0 > -0 false
    cyc(1, 4'd10, 32'h3F80_0000, 32'hBF80_0000, 0);  // R5 1 > -1
    cyc(1, 4'd10, 32'hBF80_0000, 32'hC000_0000, 0);  // R5 -1 > -2
    cyc(1, 4'd10, 32'h7FC0_0000, 32'h0000_0000, 0);  // R5 NaN false
    cyc(1, 4'd11, 32'h8000_0000, 32'h0000_0000, 0);  // R6 -0 == +0
    cyc(1, 4'd11, 32'h7FC0_0000, 32'h7FC0_0000, 0);  // R6 NaN != NaN
    cyc(1, 4'd13, 32'h1111_1111, 32'h2222_2222, 32'h8000_0000); // R7 flags set
    cyc(1, 4'd13, 32'h1111_1111, 32'h2222_2222, 32'h0);         // R7 flags clear
    cyc(1, 4'd14, 32'h4040_0000, 32'h8000_0000, 0);  // R8 -0 not negative
    cyc(1, 4'd14, 32'h4040_0000, 32'hBF00_0000, 0);  // R8 negative B
    cyc(1, 4'd14, 32'h4040_0000, 32'hFFC0_0000, 0);  // R8 negative NaN B
    cyc(1, 4'd15, 32'h0000_0000, 0, 0);              // R9 zero input
    cyc(1, 4'd15, 32'hFFFF_FFFF, 0, 0);              // R9 wraparound
    cyc(1, 4'd7,  32'hDEAD_BEEF, 32'h1, 32'h1);      // R10 unsupported
    cyc(0, 4'd12, 32'h5555_5555, 0, 0);              // R11 idle, no effect
    cyc(0, 4'd12, 32'h6666_6666, 0, 0);

    // random runs: back-to-back issues mixed with gaps (R1)
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a, b;
      a = pick_val();
      b = ($urandom % 6 == 0) ? a : pick_val();
      cyc(($urandom % 5) != 0, pick_op(), a, b, ($urandom % 2) ? $urandom : 32'h0);
    end
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule